// File: doc/BRIEF.md
# Stepped Duty Charging Current Regulator

This block holds the duty word of a small reference PWM whose averaged output sets the target charging current of a battery charger stage. On every control tick (nominally one per 100 µs) it compares a scaled battery-current sample with the target current of the present charging phase. If the current is too low by more than a deadband, the duty word goes up by one fixed step. If it is too high by more than the deadband, the word goes down by the same step. Inside the deadband the word is held. The word saturates at configurable limits and never wraps.

A battery-voltage classifier picks the charging phase on each tick: bulk, overcharge, float or off. Each phase has its own target current. Upward moves happen at a threshold, and downward moves happen only once the voltage has fallen a hysteresis margin below that threshold. A start pulse begins a charging session: the phase returns to unknown and the duty word goes to its minimum. The inputs are plain strobes and samples taken on the tick, so the block has no back-pressure. Samples are simply read in the tick cycle, and `duty_vld_o` tells downstream logic that a session is active.

Top module: `chg_current_reg`

## Requirements
- R1: After reset, `duty_o` equals DUTY_MIN (default 10), `phase_o` is 0 (unknown) and `duty_vld_o` is 0.
- R2: A cycle with `en_i`=1 and `start_i`=1 sets `phase_o` to 0, `duty_o` to DUTY_MIN and `duty_vld_o` to 1 at the next edge. Ticks are ignored while `duty_vld_o` is 0.
- R3: While `en_i`=0, the next edge forces `duty_o` to DUTY_MIN, `phase_o` to 0 and `duty_vld_o` to 0, whatever the tick and start inputs are.
- R4: On an active tick (`en_i`=1, `start_i`=0, `tick_i`=1, session valid) with target − `ibat_i` > DEADBAND (default 5), `duty_o` rises by STEP (default 4).
- R5: On an active tick with `ibat_i` − target > DEADBAND, `duty_o` falls by STEP.
- R6: On an active tick with |target − `ibat_i`| ≤ DEADBAND, `duty_o` is unchanged.
- R7: `duty_o` saturates at DUTY_MAX (default 190) and DUTY_MIN and never wraps.
- R8: Phase codes are 1 bulk, 2 overcharge, 3 float and 4 off. From unknown, an active tick selects bulk below 600, overcharge in [600,700), float in [700,800) and off at or above 800. The targets are 400, 200 and 60 for bulk, overcharge and float.
- R9: From a known phase, the phase moves up when `vbat_i` reaches a higher threshold. It moves down only when `vbat_i` is below a lower threshold minus HYST (default 20).
- R10: A tick that selects the off phase sets `duty_o` to DUTY_MIN.
- R11: `duty_o` and `phase_o` change only on active ticks, start or disable.
- R12: `pwm_o` is high for exactly `duty_o` cycles of every PWM_PERIOD (default 200) cycle window while the duty is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Charger enable |
| start_i | input | 1 | Session start pulse |
| tick_i | input | 1 | Control tick strobe |
| vbat_i | input | VW (10) | Scaled battery voltage sample |
| ibat_i | input | IW (10) | Scaled charging current sample |
| duty_o | output | DW (8) | Reference PWM duty word |
| phase_o | output | 3 | Charging phase code |
| duty_vld_o | output | 1 | Session active, duty valid |
| pwm_o | output | 1 | Reference PWM output |

## Verification
The assertions assume that `start_i` and `tick_i` are synchronous one-cycle strobes. They also assume that the samples are meaningful only in tick cycles, so any value is legal elsewhere. The bench drives every input at the falling edge. It holds each strobe for exactly one cycle, and it keeps random voltages in a window around the thresholds so that every phase and every hysteresis band is reached. Currents come either from a linear plant model (twice the duty word) or from a uniform random draw over the full sample range.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    PH_UNKNOWN = 3'd0,
    PH_BULK    = 3'd1,
    PH_OVER    = 3'd2,
    PH_FLOAT   = 3'd3,
    PH_OFF     = 3'd4
  } chg_phase_e;

  // number of voltage thresholds separating the four known phases
  localparam int NUM_THR = 3;
endpackage

// File: rtl/chg_phase_sel.sv
module chg_phase_sel
  import chg_pkg::*;
#(
  parameter int VW      = 10,
  parameter int IW      = 10,
  parameter int T_OVER  = 600,
  parameter int T_FLOAT = 700,
  parameter int T_OFF   = 800,
  parameter int HYST    = 20,
  parameter int I_BULK  = 400,
  parameter int I_OVER  = 200,
  parameter int I_FLOAT = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [VW-1:0] vbat_i,
  output chg_phase_e    phase_q_o,
  output chg_phase_e    phase_nxt_o,
  output logic [IW-1:0] target_o
);
  localparam int CW = VW + 2;

  function automatic int thr(input int idx);
    case (idx)
      0:       thr = T_OVER;
      1:       thr = T_FLOAT;
      default: thr = T_OFF;
    endcase
  endfunction

  logic [NUM_THR-1:0] up_hit, dn_hit;
  logic [CW-1:0]      v_ext, v_hys;
  logic [2:0]         up_lvl, dn_lvl, cur_lvl, nxt_lvl;
  chg_phase_e         phase_q;

  assign v_ext = {2'b00, vbat_i};
  assign v_hys = v_ext + CW'(HYST);

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    assign up_hit[g] = v_ext >= CW'(thr(g));
    assign dn_hit[g] = v_hys >= CW'(thr(g));
  end

  assign up_lvl  = 3'($countones(up_hit));
  assign dn_lvl  = 3'($countones(dn_hit));
  assign cur_lvl = 3'(phase_q) - 3'd1;

  always_comb begin
    if (phase_q == PH_UNKNOWN)  nxt_lvl = up_lvl;
    else if (up_lvl > cur_lvl)  nxt_lvl = up_lvl;
    else if (dn_lvl < cur_lvl)  nxt_lvl = dn_lvl;
    else                        nxt_lvl = cur_lvl;
  end

  assign phase_nxt_o = chg_phase_e'(nxt_lvl + 3'd1);

  always_comb begin
    case (phase_nxt_o)
      PH_BULK:  target_o = IW'(I_BULK);
      PH_OVER:  target_o = IW'(I_OVER);
      PH_FLOAT: target_o = IW'(I_FLOAT);
      default:  target_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= PH_UNKNOWN;
    else if (clear_i) phase_q <= PH_UNKNOWN;
    else if (step_i)  phase_q <= phase_nxt_o;
  end

  assign phase_q_o = phase_q;
endmodule

// File: rtl/chg_step_ctl.sv
module chg_step_ctl #(
  parameter int IW       = 10,
  parameter int DW       = 8,
  parameter int DUTY_MIN = 10,
  parameter int DUTY_MAX = 190,
  parameter int STEP     = 4,
  parameter int DEADBAND = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          off_i,
  input  logic [IW-1:0] target_i,
  input  logic [IW-1:0] ibat_i,
  output logic [DW-1:0] duty_o
);
  localparam int EW = IW + 2;
  localparam int SW = DW + 1;

  logic signed [EW-1:0] err;
  logic                 go_up, go_dn;
  logic [SW-1:0]        d_ext, d_up;
  logic [DW-1:0]        duty_q, duty_nxt;

  assign err   = $signed({2'b00, target_i}) - $signed({2'b00, ibat_i});
  assign go_up = err > $signed(EW'(DEADBAND));
  assign go_dn = err < -$signed(EW'(DEADBAND));
  assign d_ext = {1'b0, duty_q};
  assign d_up  = d_ext + SW'(STEP);

  always_comb begin
    duty_nxt = duty_q;
    if (off_i) begin
      duty_nxt = DW'(DUTY_MIN);
    end else if (go_up) begin
      if (d_up > SW'(DUTY_MAX)) duty_nxt = DW'(DUTY_MAX);
      else                      duty_nxt = d_up[DW-1:0];
    end else if (go_dn) begin
      if (d_ext < SW'(DUTY_MIN + STEP)) duty_nxt = DW'(DUTY_MIN);
      else                              duty_nxt = duty_q - DW'(STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= DW'(DUTY_MIN);
    else if (clear_i) duty_q <= DW'(DUTY_MIN);
    else if (step_i)  duty_q <= duty_nxt;
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/chg_ref_pwm.sv
module chg_ref_pwm #(
  parameter int DW     = 8,
  parameter int PERIOD = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam int MW = (CW > DW) ? CW : DW;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))   cnt <= '0;
    else                               cnt <= cnt + CW'(1);
  end

  assign pwm_o = MW'(cnt) < MW'(duty_i);
endmodule

// File: rtl/chg_current_reg.sv
module chg_current_reg
  import chg_pkg::*;
#(
  parameter int VW         = 10,
  parameter int IW         = 10,
  parameter int DW         = 8,
  parameter int DUTY_MIN   = 10,
  parameter int DUTY_MAX   = 190,
  parameter int STEP       = 4,
  parameter int DEADBAND   = 5,
  parameter int PWM_PERIOD = 200,
  parameter int T_OVER     = 600,
  parameter int T_FLOAT    = 700,
  parameter int T_OFF      = 800,
  parameter int HYST       = 20,
  parameter int I_BULK     = 400,
  parameter int I_OVER     = 200,
  parameter int I_FLOAT    = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [VW-1:0] vbat_i,
  input  logic [IW-1:0] ibat_i,
  output logic [DW-1:0] duty_o,
  output logic [2:0]    phase_o,
  output logic          duty_vld_o,
  output logic          pwm_o
);
  logic       vld_q, clear, step;
  chg_phase_e phase_q, phase_nxt;
  logic [IW-1:0] target;

  assign clear = !en_i || start_i;
  assign step  = en_i && !start_i && tick_i && vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld_q <= 1'b0;
    else if (!en_i)   vld_q <= 1'b0;
    else if (start_i) vld_q <= 1'b1;
  end

  chg_phase_sel #(
    .VW(VW), .IW(IW), .T_OVER(T_OVER), .T_FLOAT(T_FLOAT), .T_OFF(T_OFF),
    .HYST(HYST), .I_BULK(I_BULK), .I_OVER(I_OVER), .I_FLOAT(I_FLOAT)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .step_i(step),
    .vbat_i(vbat_i), .phase_q_o(phase_q), .phase_nxt_o(phase_nxt),
    .target_o(target)
  );

  chg_step_ctl #(
    .IW(IW), .DW(DW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX),
    .STEP(STEP), .DEADBAND(DEADBAND)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .step_i(step),
    .off_i(phase_nxt == PH_OFF), .target_i(target), .ibat_i(ibat_i),
    .duty_o(duty_o)
  );

  chg_ref_pwm #(.DW(DW), .PERIOD(PWM_PERIOD)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_o), .pwm_o(pwm_o)
  );

  assign phase_o    = phase_q;
  assign duty_vld_o = vld_q;
endmodule

// File: rtl/chg_current_reg_chk.sv
module chg_current_reg_chk #(
  parameter int DW       = 8,
  parameter int DUTY_MIN = 10,
  parameter int DUTY_MAX = 190,
  parameter int STEP     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          start_i,
  input logic          tick_i,
  input logic [DW-1:0] duty_o,
  input logic [2:0]    phase_o,
  input logic          duty_vld_o
);
  assert_duty_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(duty_o) >= DUTY_MIN) && (int'(duty_o) <= DUTY_MAX));

  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (int'(duty_o) == DUTY_MIN) && (phase_o == 3'd0) && !duty_vld_o);

  assert_start_inits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && start_i |=> (int'(duty_o) == DUTY_MIN) && (phase_o == 3'd0) && duty_vld_o);

  assert_quiet_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !start_i && !tick_i |=> $stable(duty_o) && $stable(phase_o));

  assert_step_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !start_i && tick_i && duty_vld_o |=>
      (int'(duty_o) == DUTY_MIN) ||
      ((int'(duty_o) - int'($past(duty_o)) <= STEP) &&
       (int'($past(duty_o)) - int'(duty_o) <= STEP)));

  assert_phase_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o <= 3'd4);
endmodule

bind chg_current_reg chg_current_reg_chk #(
  .DW(DW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .tick_i(tick_i),
  .duty_o(duty_o), .phase_o(phase_o), .duty_vld_o(duty_vld_o)
);

// File: tb/sim_chg_current_reg.sv
`timescale 1ns/1ps
module sim_chg_current_reg;
  localparam int DMIN = 10, DMAX = 190, STP = 4, DB = 5, PER = 200;

  logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic [9:0] vbat_i = '0, ibat_i = '0;
  logic [7:0] duty_o;
  logic [2:0] phase_o;
  logic duty_vld_o, pwm_o;

  chg_current_reg u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .tick_i(tick_i),
    .vbat_i(vbat_i), .ibat_i(ibat_i), .duty_o(duty_o), .phase_o(phase_o),
    .duty_vld_o(duty_vld_o), .pwm_o(pwm_o)
  );

  always #10 clk = ~clk;

  int vecs = 0, bad = 0;
  int m_duty = DMIN, m_phase = 0, m_vld = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int up_count(input int v);
    return int'(v >= 600) + int'(v >= 700) + int'(v >= 800);
  endfunction
  function automatic int dn_count(input int v);
    return int'(v >= 580) + int'(v >= 680) + int'(v >= 780);
  endfunction
  function automatic int next_phase(input int ph, input int v);
    int u = up_count(v), d = dn_count(v), c = ph - 1;
    if (ph == 0) return u + 1;
    if (u > c) return u + 1;
    if (d < c) return d + 1;
    return ph;
  endfunction
  function automatic int target_of(input int ph);
    case (ph)
      1: return 400;
      2: return 200;
      3: return 60;
      default: return 0;
    endcase
  endfunction
  function automatic int stepped(input int d, input int tgt, input int i);
    if (tgt - i > DB) return (d + STP > DMAX) ? DMAX : d + STP;
    if (i - tgt > DB) return (d - STP < DMIN) ? DMIN : d - STP;
    return d;
  endfunction

  task automatic cyc(input string tag, input bit e, input bit s, input bit t,
                     input int v, input int i);
    en_i = e; start_i = s; tick_i = t; vbat_i = 10'(v); ibat_i = 10'(i);
    @(negedge clk);
    if (!e) begin m_duty = DMIN; m_phase = 0; m_vld = 0; end
    else if (s) begin m_duty = DMIN; m_phase = 0; m_vld = 1; end
    else if (t && m_vld != 0) begin
      m_phase = next_phase(m_phase, v);
      m_duty  = (m_phase == 4) ? DMIN : stepped(m_duty, target_of(m_phase), i);
    end
    chk({tag, " duty"}, int'(duty_o), m_duty);
    chk({tag, " phase"}, int'(phase_o), m_phase);
    chk({tag, " vld"}, int'(duty_vld_o), m_vld);
    tick_i = 0; start_i = 0;
  endtask

  task automatic plant_tick(input string tag, input int v);
    cyc(tag, 1, 0, 1, v, 2 * int'(duty_o));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 duty", int'(duty_o), DMIN);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 vld", int'(duty_vld_o), 0);

    cyc("R2 tick-before-start", 1, 0, 1, 650, 0);
    cyc("R2 start", 1, 1, 0, 650, 0);

    // R4 / R6 convergence in overcharge phase (R8: 650 -> phase 2)
    for (int k = 0; k < 60; k++) plant_tick("R4 converge", 650);
    chk("R8 overcharge code", int'(phase_o), 2);
    hi = 2 * int'(duty_o) - 200;
    chk("R6 settled in band", int'(hi <= DB && hi >= -DB), 1);

    // deadband edges
    cyc("R6 upper edge", 1, 0, 1, 650, 205);
    cyc("R5 above band", 1, 0, 1, 650, 206);
    cyc("R6 lower edge", 1, 0, 1, 650, 195);
    cyc("R4 below band", 1, 0, 1, 650, 194);
    cyc("R11 idle", 1, 0, 0, 900, 0);

    // R9 hysteresis walk
    cyc("R9 stay over", 1, 0, 1, 699, 200);
    cyc("R9 up float", 1, 0, 1, 700, 60);
    cyc("R9 hold float", 1, 0, 1, 680, 60);
    cyc("R9 down over", 1, 0, 1, 679, 200);

    // R7 saturate high in bulk
    for (int k = 0; k < 60; k++) plant_tick("R7 bulk", 500);
    chk("R7 at max", int'(duty_o), DMAX);
    cyc("R7 hold max", 1, 0, 1, 500, 0);

    // R10 off phase
    cyc("R10 off", 1, 0, 1, 820, 0);
    cyc("R9 stay off", 1, 0, 1, 780, 0);
    cyc("R9 off to float", 1, 0, 1, 779, 1023);
    for (int k = 0; k < 5; k++) cyc("R7 hold min", 1, 0, 1, 760, 1023);
    chk("R7 at min", int'(duty_o), DMIN);

    cyc("R3 disable", 0, 0, 1, 650, 0);
    cyc("R3 tick while off", 0, 1, 1, 650, 0);

    // R12 pwm duty count
    cyc("R2 restart", 1, 1, 0, 650, 0);
    for (int k = 0; k < 20; k++) plant_tick("R4 ramp", 650);
    hi = 0;
    for (int k = 0; k < PER; k++) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
    chk("R12 pwm high count", hi, int'(duty_o));

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom_range(0, 99));
      int v = int'($urandom_range(540, 860));
      int i = ($urandom_range(0, 1) != 0) ? 2 * int'(duty_o) : int'($urandom_range(0, 1023));
      if (r < 2)       cyc("R3 rnd", 0, 0, 1, v, i);
      else if (r < 5)  cyc("R2 rnd", 1, 1, 1, v, i);
      else if (r < 30) cyc("R11 rnd", 1, 0, 0, v, i);
      else             cyc("R5 rnd", 1, 0, 1, v, i);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule